// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular receive area of local RAM. The area is split into 256-byte pages. Two fixed page numbers bound the ring: a first page and a limit page, which is one past the last usable page. A current-page register marks where the next frame will begin. A boundary page, owned by the host, marks the oldest frame the host has not yet consumed. Every pointer is an 8-bit page number, and a RAM byte address is the page number followed by an 8-bit offset.

A frame arrives as one byte per cycle. The block leaves a 4-byte slot at the start of the frame's first page and writes the data after it. It moves on to the next page when a page fills, and after the last usable page it returns to the first page. When the frame ends, the block fills the slot over four cycles: a status byte, the page where the following frame will begin, and a 16-bit length. It then moves the current page to that following page.

If a data byte would enter the boundary page, the ring is full. The block stops writing, raises a sticky overflow flag and discards the rest of the frame. While the flag is set, new frames are discarded. Software clears the flag with a pulse.

Top module: `rxring_mgr`

## Requirements
- R1: After reset, `ovf_flag` is 0, `cur_pg` is 0 and `mem_we` is 0.
- R2: A `ring_init` pulse loads `init_pg` into the current page. The next frame's first data byte goes to byte address `{init_pg, 8'h04}`.
- R3: Data byte k of a frame (k from 0) is written at offset (4+k) mod 256 of the page that lies (4+k) div 256 pages after the frame's first page, counted around the ring.
- R4: The page that follows page `stop_pg-1` is `start_pg`. This applies both to data and to the next-packet pointer.
- R5: In the four cycles after `frm_end`, the header is written at offsets 0 to 3 of the frame's first page. The bytes are, in order: the status byte, the next-packet page, then a 16-bit count (low byte first) equal to the data length plus 4.
- R6: The next-packet page is the frame's first page advanced by ceil((length+4)/256) pages around the ring. `cur_pg` takes this value when the header write completes.
- R7: `frm_abort` during a frame leaves `cur_pg` unchanged. The next frame again starts writing at offset 4 of the same page.
- R8: A data byte that would land at offset 0 of the boundary page is not written. `ovf_flag` is set, the rest of the frame is dropped and `cur_pg` is unchanged.
- R9: A frame whose first byte arrives while `cur_pg` equals `bnd_pg` is dropped without any write, and `ovf_flag` is set.
- R10: While `ovf_flag` is 1, frames are dropped with no RAM write and `cur_pg` does not move. The flag stays at 1 until an `ovf_clr` pulse, which returns it to 0.
- R11: `frm_end` or `frm_abort` while no frame is in progress causes no RAM write and no change of `cur_pg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pg | input | 8 | First page of the ring (fixed) |
| stop_pg | input | 8 | One past the last ring page (fixed) |
| bnd_pg | input | 8 | Host boundary page |
| ring_init | input | 1 | Load `init_pg` as the current page |
| init_pg | input | 8 | Initial current page |
| byte_vld | input | 1 | Frame data byte valid |
| byte_dat | input | 8 | Frame data byte |
| frm_end | input | 1 | Frame complete (not together with `byte_vld`) |
| frm_stat | input | 8 | Receive status, sampled with `frm_end` |
| frm_abort | input | 1 | Discard the frame in progress |
| ovf_clr | input | 1 | Clear the overflow flag |
| mem_we | output | 1 | RAM byte write enable |
| mem_addr | output | 16 | RAM byte address {page, offset} |
| mem_wdat | output | 8 | RAM write data |
| cur_pg | output | 8 | Current page register |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A sweep of frame lengths is run over a six-page ring. With the host boundary always set just behind the current page, the lengths cover 1 byte, lengths that fill the first page exactly or overshoot it by one, multi-page frames that wrap from the limit page back to the first page, and a frame that fills every free page. These lengths separate off-by-one errors in page rounding, header length and wrap. A further set of patterns targets the boundary and stop handling. A frame is cut off on entering the boundary page, and a checked sentinel byte there must stay intact. A frame starts with the current page equal to the boundary, frames arrive while the flag is set, and a frame is aborted. Each of these must leave the current page where it was, which tells a held pointer from a wrongly advanced one.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int PG_W    = 8;
  localparam int OFF_W   = 8;
  localparam int ADDR_W  = PG_W + OFF_W;
  localparam int CNT_W   = 16;
  localparam int HDR_LEN = 4;
  localparam int HIDX_W  = $clog2(HDR_LEN);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } rx_st_e;

  function automatic logic [PG_W-1:0] pg_next(input logic [PG_W-1:0] p,
                                               input logic [PG_W-1:0] s,
                                               input logic [PG_W-1:0] e);
    logic [PG_W-1:0] q;
    q = p + 1'b1;
    return (q == e) ? s : q;
  endfunction
endpackage

// File: rtl/rxr_wptr.sv
module rxr_wptr
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PG_W-1:0]   load_pg,
  input  logic              step,
  input  logic [PG_W-1:0]   start_pg,
  input  logic [PG_W-1:0]   stop_pg,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  byte_cnt
);
  localparam logic [OFF_W-1:0] OFF_FIRST = OFF_W'(HDR_LEN);
  localparam logic [OFF_W-1:0] OFF_LAST  = {OFF_W{1'b1}};

  logic [PG_W-1:0]  pg_q, pg_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    pg_d  = pg_q;
    off_d = off_q;
    cnt_d = cnt_q;
    en    = load | step;
    if (load) begin
      pg_d  = load_pg;
      off_d = OFF_FIRST;
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (off_q == OFF_LAST) begin
        off_d = '0;
        pg_d  = pg_next(pg_q, start_pg, stop_pg);
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= '0;
      off_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      pg_q  <= pg_d;
      off_q <= off_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_addr  = {pg_q, off_q};
  assign byte_cnt = cnt_q;

  // R4: leaving the last usable page lands on the first ring page
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && off_q == OFF_LAST && pg_q == stop_pg - 1'b1)
      |=> (wr_addr[ADDR_W-1:OFF_W] == $past(start_pg) && wr_addr[OFF_W-1:0] == '0));
endmodule

// File: rtl/rxr_ovf.sv
module rxr_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PG_W-1:0]   start_pg,
  input  logic [PG_W-1:0]   stop_pg,
  input  logic [PG_W-1:0]   bnd_pg,
  input  logic              ring_init,
  input  logic [PG_W-1:0]   init_pg,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              frm_end,
  input  logic [7:0]        frm_stat,
  input  logic              frm_abort,
  input  logic              ovf_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdat,
  output logic [PG_W-1:0]   cur_pg,
  output logic              ovf_flag
);
  localparam logic [HIDX_W-1:0] HIDX_LAST = HIDX_W'(HDR_LEN - 1);

  rx_st_e            st_q, st_d;
  logic [PG_W-1:0]   cur_q, cur_d;
  logic [HIDX_W-1:0] hidx_q, hidx_d;
  logic [7:0]        stat_q;
  logic [PG_W-1:0]   nxt_q, nxt_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic              latch_end;

  logic              wp_load, wp_step;
  logic [PG_W-1:0]   wp_load_pg;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  byte_cnt;
  logic              ovf_set;
  logic              we_c;
  logic [PG_W-1:0]   wr_pg;
  logic [OFF_W-1:0]  wr_off;

  assign wr_pg  = wr_addr[ADDR_W-1:OFF_W];
  assign wr_off = wr_addr[OFF_W-1:0];

  rxr_wptr u_wptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wp_load),
    .load_pg  (wp_load_pg),
    .step     (wp_step),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .wr_addr  (wr_addr),
    .byte_cnt (byte_cnt)
  );

  rxr_ovf u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovf_set),
    .clr   (ovf_clr),
    .flag  (ovf_flag)
  );

  // end-of-frame header values
  always_comb begin
    nxt_d = (wr_off == '0) ? wr_pg : pg_next(wr_pg, start_pg, stop_pg);
    len_d = byte_cnt + CNT_W'(HDR_LEN);
  end

  // control
  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    hidx_d     = hidx_q;
    wp_load    = 1'b0;
    wp_load_pg = cur_q;
    wp_step    = 1'b0;
    we_c       = 1'b0;
    ovf_set    = 1'b0;
    latch_end  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (byte_vld) begin
          if (ovf_flag) begin
            st_d = ST_DROP;
          end else if (cur_q == bnd_pg) begin
            ovf_set = 1'b1;
            st_d    = ST_DROP;
          end else begin
            we_c    = 1'b1;
            wp_step = 1'b1;
            st_d    = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (frm_abort) begin
          wp_load = 1'b1;
          st_d    = ST_IDLE;
        end else if (frm_end) begin
          latch_end = 1'b1;
          hidx_d    = '0;
          st_d      = ST_HDR;
        end else if (byte_vld) begin
          if (wr_off == '0 && wr_pg == bnd_pg) begin
            ovf_set = 1'b1;
            st_d    = ST_DROP;
          end else begin
            we_c    = 1'b1;
            wp_step = 1'b1;
          end
        end
      end
      ST_DROP: begin
        if (frm_end || frm_abort) begin
          wp_load = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_HDR: begin
        we_c   = 1'b1;
        hidx_d = hidx_q + 1'b1;
        if (hidx_q == HIDX_LAST) begin
          cur_d      = nxt_q;
          wp_load    = 1'b1;
          wp_load_pg = nxt_q;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (ring_init) begin
      cur_d      = init_pg;
      wp_load    = 1'b1;
      wp_load_pg = init_pg;
      wp_step    = 1'b0;
      we_c       = 1'b0;
      ovf_set    = 1'b0;
      latch_end  = 1'b0;
      st_d       = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      hidx_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      hidx_q <= hidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      nxt_q  <= '0;
      len_q  <= '0;
    end else if (latch_end) begin
      stat_q <= frm_stat;
      nxt_q  <= nxt_d;
      len_q  <= len_d;
    end
  end

  // write port
  always_comb begin
    mem_we = we_c;
    if (st_q == ST_HDR) begin
      mem_addr = {cur_q, {(OFF_W-HIDX_W){1'b0}}, hidx_q};
      unique case (hidx_q)
        2'd0:    mem_wdat = stat_q;
        2'd1:    mem_wdat = nxt_q;
        2'd2:    mem_wdat = len_q[7:0];
        default: mem_wdat = len_q[15:8];
      endcase
    end else begin
      mem_addr = wr_addr;
      mem_wdat = byte_dat;
    end
  end

  assign cur_pg = cur_q;

  // R3: every write stays inside the ring
  p_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] >= start_pg && mem_addr[ADDR_W-1:OFF_W] < stop_pg));
  // R8: the host boundary page is never written
  p_no_bnd_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] != bnd_pg));
  // R8: a dropped frame writes nothing
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |-> !mem_we);
  // R7: an abort keeps the current page
  p_abort_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECV && frm_abort && !ring_init) |=> $stable(cur_q));
endmodule

// File: tb/rxring_mgr_tb.sv
module rxring_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  start_pg, stop_pg, bnd_pg, init_pg, byte_dat, frm_stat;
  logic        ring_init, byte_vld, frm_end, frm_abort, ovf_clr;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdat, cur_pg;
  logic        ovf_flag;

  int n_chk = 0, n_fail = 0, we_cnt = 0;
  bit done = 0;
  logic [7:0] mem [0:65535];

  always #2 clk = ~clk;

  rxring_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .ring_init(ring_init), .init_pg(init_pg),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .frm_end(frm_end),
    .frm_stat(frm_stat), .frm_abort(frm_abort), .ovf_clr(ovf_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdat(mem_wdat),
    .cur_pg(cur_pg), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdat;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ring_adv(logic [7:0] p, int n);
    int np = stop_pg - start_pg;
    return 8'(start_pg + ((p - start_pg + n) % np));
  endfunction

  function automatic logic [7:0] pat(int k, logic [7:0] seed);
    return 8'(k * 7 + seed);
  endfunction

  task automatic push_bytes(int len, logic [7:0] seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk); byte_vld = 1'b1; byte_dat = pat(k, seed);
    end
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic end_frame(logic [7:0] st);
    @(negedge clk); frm_end = 1'b1; frm_stat = st;
    @(negedge clk); frm_end = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic good_frame(int len, logic [7:0] st, logic [7:0] seed);
    logic [7:0] c0, nx;
    int w0, bad;
    int cnt;
    c0 = cur_pg; w0 = we_cnt; cnt = len + 4;
    nx = ring_adv(c0, (cnt + 255) / 256);
    push_bytes(len, seed);
    end_frame(st);
    chk(mem[{c0, 8'd0}] == st, "R5 status byte", mem[{c0, 8'd0}], st);
    chk(mem[{c0, 8'd1}] == nx, "R5 next-page byte", mem[{c0, 8'd1}], nx);
    chk(mem[{c0, 8'd2}] == cnt[7:0], "R5 count low", mem[{c0, 8'd2}], cnt[7:0]);
    chk(mem[{c0, 8'd3}] == cnt[15:8], "R5 count high", mem[{c0, 8'd3}], cnt[15:8]);
    chk(cur_pg == nx, "R6 current page advance", cur_pg, nx);
    chk(we_cnt - w0 == cnt, "R3 write count", we_cnt - w0, cnt);
    bad = 0;
    for (int k = 0; k < len; k++) begin
      int off = 4 + k;
      logic [15:0] a = {ring_adv(c0, off / 256), 8'(off % 256)};
      if (mem[a] != pat(k, seed)) bad++;
    end
    chk(bad == 0, "R3/R4 data placement and wrap", bad, 0);
  endtask

  initial begin
    int lens [12] = '{1, 60, 251, 252, 253, 300, 507, 508, 509, 700, 1000, 1276};
    logic [7:0] c0;
    int w0;
    for (int i = 0; i < 65536; i++) mem[i] = 8'hEE;
    rst_n = 1'b0; start_pg = 8'h40; stop_pg = 8'h46; bnd_pg = 8'h40;
    init_pg = 8'h00; byte_dat = 8'h00; frm_stat = 8'h00;
    ring_init = 0; byte_vld = 0; frm_end = 0; frm_abort = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    chk(ovf_flag == 1'b0, "R1 ovf after reset", ovf_flag, 0);
    chk(cur_pg == 8'h00, "R1 cur after reset", cur_pg, 0);
    chk(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    init_pg = 8'h41; ring_init = 1'b1;
    @(negedge clk); ring_init = 1'b0;
    chk(cur_pg == 8'h41, "R2 init load", cur_pg, 8'h41);
    bnd_pg = 8'h40;
    good_frame(5, 8'h21, 8'h10);
    chk(mem[16'h4104] == pat(0, 8'h10), "R2 first data byte at init page +4", mem[16'h4104], pat(0, 8'h10));

    // length sweep; host always drained up to just behind current page
    foreach (lens[i]) begin
      bnd_pg = ring_adv(cur_pg, 5);
      good_frame(lens[i], 8'(8'h01 + i), 8'(i * 13));
    end

    // R7 abort
    bnd_pg = ring_adv(cur_pg, 5);
    c0 = cur_pg;
    push_bytes(100, 8'h77);
    @(negedge clk); frm_abort = 1'b1;
    @(negedge clk); frm_abort = 1'b0;
    repeat (3) @(negedge clk);
    chk(cur_pg == c0, "R7 abort keeps page", cur_pg, c0);
    good_frame(20, 8'h55, 8'h33);
    chk(mem[{c0, 8'd4}] == pat(0, 8'h33), "R7 restart at offset 4", mem[{c0, 8'd4}], pat(0, 8'h33));

    // R11 stray end/abort in idle
    c0 = cur_pg; w0 = we_cnt;
    @(negedge clk); frm_end = 1'b1;
    @(negedge clk); frm_end = 1'b0; frm_abort = 1'b1;
    @(negedge clk); frm_abort = 1'b0;
    repeat (6) @(negedge clk);
    chk(we_cnt == w0, "R11 no write on idle end", we_cnt - w0, 0);
    chk(cur_pg == c0, "R11 cur unchanged", cur_pg, c0);

    // R9 start while cur == boundary
    bnd_pg = cur_pg; w0 = we_cnt;
    push_bytes(10, 8'h01); end_frame(8'h02);
    chk(ovf_flag == 1'b1, "R9 ovf set", ovf_flag, 1);
    chk(we_cnt == w0, "R9 no write", we_cnt - w0, 0);
    chk(cur_pg == c0, "R9 cur unchanged", cur_pg, c0);

    // R10 frames dropped while flag set
    bnd_pg = ring_adv(cur_pg, 5); w0 = we_cnt;
    push_bytes(10, 8'h02); end_frame(8'h03);
    chk(we_cnt == w0, "R10 dropped while flag set", we_cnt - w0, 0);
    chk(ovf_flag == 1'b1, "R10 flag sticky", ovf_flag, 1);
    chk(cur_pg == c0, "R10 cur unchanged", cur_pg, c0);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk(ovf_flag == 1'b0, "R10 flag cleared", ovf_flag, 0);

    // R8 overflow into boundary page
    bnd_pg = ring_adv(cur_pg, 1);
    mem[{bnd_pg, 8'd0}] = 8'h5A;
    w0 = we_cnt;
    push_bytes(300, 8'h44); end_frame(8'h04);
    chk(ovf_flag == 1'b1, "R8 ovf set", ovf_flag, 1);
    chk(we_cnt - w0 == 252, "R8 bytes written before boundary", we_cnt - w0, 252);
    chk(mem[{bnd_pg, 8'd0}] == 8'h5A, "R8 boundary page untouched", mem[{bnd_pg, 8'd0}], 8'h5A);
    chk(cur_pg == c0, "R8 cur unchanged", cur_pg, c0);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    bnd_pg = ring_adv(cur_pg, 5);
    good_frame(40, 8'h66, 8'h09);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule